// File: doc/BRIEF.md
# Debug Mailbox Pair

This block joins a processor core and an external debugger through two one-entry, 32-bit mailboxes. In the inbound direction the debugger posts a word that the core later collects. In the outbound direction the core posts a word that the debugger later collects. Each mailbox has an occupancy flag. The posting side sets the flag and the collecting side clears it, so each agent can poll the flag to tell when the other side has acted.

The debugger posts inbound words on a valid/ready channel. `dbg_wr_ready` is high exactly when the inbound mailbox is empty. The channel gives no back-pressure in the stalling sense: a word offered while `dbg_wr_ready` is low is discarded, and the debugger has to offer it again. All other accesses are single-cycle strobes, and read data is always visible on the data outputs. Both occupancy flags are exported on a 32-bit status word. A lockout control can stop user-mode code on the core from reaching the mailboxes. A blocked access raises a trap output in that same cycle and has no effect on the mailboxes.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset both occupancy flags are 0 and the whole status word reads 0.
- R2: A debugger write (`dbg_wr_valid`=1) while the inbound mailbox is empty stores `dbg_wr_data` and sets the inbound flag from the next cycle. From that cycle on, `core_rd_data` shows the stored word.
- R3: A core read (`core_rd_en`=1, not trapped) while the inbound mailbox is full clears the inbound flag from the next cycle.
- R4: `dbg_wr_ready` equals the inverse of the inbound flag. A debugger write while the inbound flag is set is dropped: the stored word and the flag do not change.
- R5: A core write (`core_wr_en`=1, not trapped) stores `core_wr_data` and sets the outbound flag from the next cycle. `dbg_rd_data` shows the stored word.
- R6: A debugger read (`dbg_rd_en`=1) clears the outbound flag from the next cycle, unless a core write happens in the same cycle.
- R7: A core write while the outbound flag is set replaces the stored word, and the flag stays set.
- R8: When a core write and a debugger read of the outbound mailbox fall in the same cycle, the set wins. The flag stays set and the new word is kept.
- R9: A core read while the inbound mailbox is empty returns the last stored word and changes no flag.
- R10: The status word holds the inbound flag at bit 30 and the outbound flag at bit 29. All other status bits read 0.
- R11: When `lock_user`=1 and `core_user`=1, any core read or write drives `core_trap` high in that cycle and changes no flag and no stored word. In every other case `core_trap` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_user | input | 1 | 1 = user-mode core accesses are blocked |
| core_user | input | 1 | 1 = the current core access is from user mode |
| core_rd_en | input | 1 | Core collects the inbound word |
| core_rd_data | output | 32 | Inbound mailbox contents |
| core_wr_en | input | 1 | Core posts an outbound word |
| core_wr_data | input | 32 | Outbound word to post |
| core_trap | output | 1 | Blocked core access (undefined-instruction trap) |
| dbg_wr_valid | input | 1 | Debugger offers an inbound word |
| dbg_wr_ready | output | 1 | Inbound mailbox empty; an offer is accepted |
| dbg_wr_data | input | 32 | Inbound word offered |
| dbg_rd_en | input | 1 | Debugger collects the outbound word |
| dbg_rd_data | output | 32 | Outbound mailbox contents |
| status | output | 32 | Bit 30 inbound flag, bit 29 outbound flag |

## Verification
The hardest cases to reach are collisions within a single cycle. One is a core write that meets a debugger read of the outbound mailbox. The other is a trapped core access that coincides with traffic from the debugger. Each of these needs particular flag states to have been set up in earlier cycles. The stimulus first runs directed sequences that build those states. It then sweeps 2048 cycles in which each cycle's six control inputs come from a fixed arithmetic mix of the cycle index, so that every control combination occurs from each flag state. A bench-side model derived from the requirements predicts every output.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;
  localparam int STATUS_W    = 32;
  localparam int IN_FLAG_BIT = 30;
  localparam int OUT_FLAG_BIT = 29;
endpackage

// File: rtl/dbgmb_gate.sv
// Screens core accesses against the user-mode lockout.
module dbgmb_gate (
  input  logic lock_user,
  input  logic core_user,
  input  logic rd_req,
  input  logic wr_req,
  output logic rd_ok,
  output logic wr_ok,
  output logic trap
);
  logic blocked;
  assign blocked = lock_user & core_user;
  assign rd_ok   = rd_req & ~blocked;
  assign wr_ok   = wr_req & ~blocked;
  assign trap    = (rd_req | wr_req) & blocked;
endmodule

// File: rtl/dbgmb_slot.sv
// One-entry mailbox with an occupancy flag; a put beats a take.
module dbgmb_slot #(
  parameter int W         = 32,
  parameter bit DROP_FULL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         put,
  input  logic [W-1:0] put_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  logic accept;

  generate
    if (DROP_FULL) begin : g_drop
      assign accept = put & ~full;
    end else begin : g_over
      assign accept = put;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (accept) begin
        full <= 1'b1;
        data <= put_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbgmb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lock_user,
  input  logic                core_user,
  input  logic                core_rd_en,
  output logic [DATA_W-1:0]   core_rd_data,
  input  logic                core_wr_en,
  input  logic [DATA_W-1:0]   core_wr_data,
  output logic                core_trap,
  input  logic                dbg_wr_valid,
  output logic                dbg_wr_ready,
  input  logic [DATA_W-1:0]   dbg_wr_data,
  input  logic                dbg_rd_en,
  output logic [DATA_W-1:0]   dbg_rd_data,
  output logic [STATUS_W-1:0] status
);
  logic rd_ok, wr_ok;
  logic in_full, out_full;

  dbgmb_gate u_gate (
    .lock_user (lock_user),
    .core_user (core_user),
    .rd_req    (core_rd_en),
    .wr_req    (core_wr_en),
    .rd_ok     (rd_ok),
    .wr_ok     (wr_ok),
    .trap      (core_trap)
  );

  // Inbound: debugger -> core, offers dropped while occupied.
  dbgmb_slot #(.W(DATA_W), .DROP_FULL(1'b1)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .put      (dbg_wr_valid),
    .put_data (dbg_wr_data),
    .take     (rd_ok),
    .full     (in_full),
    .data     (core_rd_data)
  );

  // Outbound: core -> debugger, core overwrites while occupied.
  dbgmb_slot #(.W(DATA_W), .DROP_FULL(1'b0)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .put      (wr_ok),
    .put_data (core_wr_data),
    .take     (dbg_rd_en),
    .full     (out_full),
    .data     (dbg_rd_data)
  );

  assign dbg_wr_ready = ~in_full;

  always_comb begin
    status = '0;
    status[IN_FLAG_BIT]  = in_full;
    status[OUT_FLAG_BIT] = out_full;
  end
endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk
  import dbgmb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lock_user,
  input logic                core_user,
  input logic                core_rd_en,
  input logic [DATA_W-1:0]   core_rd_data,
  input logic                core_wr_en,
  input logic [DATA_W-1:0]   core_wr_data,
  input logic                core_trap,
  input logic                dbg_wr_valid,
  input logic                dbg_wr_ready,
  input logic [DATA_W-1:0]   dbg_wr_data,
  input logic                dbg_rd_en,
  input logic [DATA_W-1:0]   dbg_rd_data,
  input logic [STATUS_W-1:0] status
);
  logic in_f, out_f;
  assign in_f  = status[IN_FLAG_BIT];
  assign out_f = status[OUT_FLAG_BIT];

  AST_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr_valid && !in_f |=> in_f && core_rd_data == $past(dbg_wr_data)); // R2
  AST_IN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    core_rd_en && !core_trap && in_f |=> !in_f); // R3
  AST_IN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr_valid && in_f |=> $stable(core_rd_data)); // R4
  AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr_en && !core_trap |=> out_f && dbg_rd_data == $past(core_wr_data)); // R8
  AST_OUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_rd_en && !(core_wr_en && !core_trap) |=> !out_f); // R6
  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~((32'd1 << IN_FLAG_BIT) | (32'd1 << OUT_FLAG_BIT))) == '0); // R10
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    core_trap |-> core_user && lock_user && (core_rd_en || core_wr_en)); // R11
  AST_TRAP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    core_trap && !dbg_wr_valid && !dbg_rd_en |=> $stable(status) && $stable(dbg_rd_data)); // R11
endmodule

bind dbg_mailbox dbg_mailbox_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/dbg_mailbox_tb_top.sv
module dbg_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lock_user, core_user, core_rd_en, core_wr_en, dbg_wr_valid, dbg_rd_en;
  logic [31:0] core_wr_data, dbg_wr_data;
  logic [31:0] core_rd_data, dbg_rd_data, status;
  logic        core_trap, dbg_wr_ready;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_in, m_out;
  logic        m_inf, m_outf;

  always #10 clk = ~clk;

  dbg_mailbox dut_i (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit dwv, input logic [31:0] dwd, input bit drd,
                      input bit crd, input bit cwr, input logic [31:0] cwd,
                      input bit usr, input bit lk);
    bit trap_e;
    @(negedge clk);
    dbg_wr_valid = dwv; dbg_wr_data = dwd; dbg_rd_en = drd;
    core_rd_en = crd; core_wr_en = cwr; core_wr_data = cwd;
    core_user = usr; lock_user = lk;
    #1;
    trap_e = (crd | cwr) & usr & lk;
    chk({31'd0, core_trap}, {31'd0, trap_e}, "R11");
    chk({31'd0, dbg_wr_ready}, {31'd0, ~m_inf}, "R4");
    chk(core_rd_data, m_in, "R9");
    chk(dbg_rd_data, m_out, "R5");
    chk(status, {1'b0, m_inf, m_outf, 29'd0}, "R10");
    @(posedge clk);
    if (dwv && !m_inf) begin m_in = dwd; m_inf = 1'b1; end
    else if (crd && !trap_e) m_inf = 1'b0;
    if (cwr && !trap_e) begin m_out = cwd; m_outf = 1'b1; end
    else if (drd) m_outf = 1'b0;
    #5;
  endtask

  task automatic idle();
    step(0, 32'h0, 0, 0, 0, 32'h0, 0, 0);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_in = '0; m_out = '0; m_inf = 0; m_outf = 0;
    rst_n = 0; lock_user = 0; core_user = 0; core_rd_en = 0; core_wr_en = 0;
    dbg_wr_valid = 0; dbg_rd_en = 0; core_wr_data = '0; dbg_wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk(status, 32'h0, "R1");
    chk({31'd0, dbg_wr_ready}, 32'd1, "R1");

    step(1, 32'hA5A5_0001, 0, 0, 0, 0, 0, 0);
    chk(status, 32'h4000_0000, "R2"); chk(core_rd_data, 32'hA5A5_0001, "R2");
    step(1, 32'h1111_1111, 0, 0, 0, 0, 0, 0);
    chk(core_rd_data, 32'hA5A5_0001, "R4"); chk(status, 32'h4000_0000, "R4");
    step(0, 0, 0, 1, 0, 0, 1, 0);
    chk(status, 32'h0, "R3");
    step(0, 0, 0, 1, 0, 0, 0, 0);
    chk(status, 32'h0, "R9"); chk(core_rd_data, 32'hA5A5_0001, "R9");
    step(0, 0, 0, 0, 1, 32'h0000_0022, 0, 0);
    chk(status, 32'h2000_0000, "R5"); chk(dbg_rd_data, 32'h22, "R5");
    step(0, 0, 0, 0, 1, 32'h0000_0033, 0, 0);
    chk(status, 32'h2000_0000, "R7"); chk(dbg_rd_data, 32'h33, "R7");
    step(0, 0, 1, 0, 1, 32'h0000_0044, 0, 0);
    chk(status, 32'h2000_0000, "R8"); chk(dbg_rd_data, 32'h44, "R8");
    step(0, 0, 1, 0, 0, 0, 0, 0);
    chk(status, 32'h0, "R6");
    step(0, 0, 0, 0, 1, 32'h0000_0055, 1, 1);
    chk(status, 32'h0, "R11"); chk(dbg_rd_data, 32'h44, "R11");
    step(1, 32'h0000_0066, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 1, 1);
    chk(status, 32'h4000_0000, "R11");
    idle();

    for (int i = 0; i < 2048; i++) begin
      logic [31:0] h;
      h = (i * 32'h9E37_79B1) ^ (i >> 3);
      step(h[7], h ^ 32'h5A00_0000, h[11], h[13], h[17], ~h, h[19], h[23]);
    end
    idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule